// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table held in memory. A translate request arrives over a valid/ready handshake together with the paging-enable bit and the directory base register, both sampled in the cycle the request is taken. With paging enabled, the walker first reads a directory entry, then a page table entry, through a single read port of variable latency. It then joins the page frame from the table entry to the byte offset of the linear address. With paging disabled it hands the linear address back unchanged and touches no memory.

Each entry carries a present flag in bit 0. A clear flag in either level ends the walk early and the block reports a fault instead of an address. Nothing is cached: every request fetches both entries afresh. The walker's controller has four states. `ST_IDLE` takes a request (transition *accept*). `ST_READ_PDE` waits for the directory entry (transitions *pde_hit* to `ST_READ_PTE`, *pde_miss* to `ST_DONE`). `ST_READ_PTE` waits for the table entry (transitions *pte_hit* or *pte_miss* to `ST_DONE`). `ST_DONE` presents the result for one cycle (transition *retire* back to `ST_IDLE`). The transition *bypass* goes from `ST_IDLE` straight to `ST_DONE` when paging is off.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `mem_rd_req`, `done`, `fault` and `phys_addr` are all 0.
- R2: `req_ready` is 1 only in the idle state; a `req_valid` seen while the walker is busy is ignored and starts no walk.
- R3: A request taken with `pg_en` = 0 produces `done` in the next cycle with `phys_addr` equal to the request's linear address and `fault` = 0, and no memory read is issued.
- R4: With paging on, the cycle after a request is taken the walker asserts `mem_rd_req` at the directory entry address {base[31:12], lin[31:22], 2'b00}; the low 12 bits of `dir_base` have no effect.
- R5: After a present directory entry returns, the next read targets the table entry address {pde[31:12], lin[21:12], 2'b00}.
- R6: After a present table entry returns, `done` rises in the next cycle with `phys_addr` = {pte[31:12], lin[11:0]} and `fault` = 0.
- R7: A directory entry with bit 0 = 0 ends the walk: no table read follows, and `done` rises in the next cycle with `fault` = 1 and `phys_addr` = 0.
- R8: A table entry with bit 0 = 0 makes `done` rise in the next cycle with `fault` = 1 and `phys_addr` = 0.
- R9: `mem_rd_req` stays high with an unchanged `mem_rd_addr` until a cycle with `mem_rd_valid` = 1; a response in the same cycle as the request's first cycle is accepted; `mem_rd_addr` is 0 while no read is requested.
- R10: `done` is a one-cycle pulse followed by the idle state; outside that cycle `phys_addr` and `fault` are 0.
- R11: `pg_en` and `dir_base` are sampled only when a request is taken; changes to them during a walk do not alter its addresses or result.
- R12: `mem_rd_valid` asserted while no read is requested has no effect on state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pg_en | input | 1 | Paging enable, sampled when a request is taken |
| dir_base | input | 32 | Physical base of the page directory; low 12 bits ignored |
| req_valid | input | 1 | Translate request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory; bit 0 is the present flag |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Translation failed on a non-present entry (valid with done) |
| phys_addr | output | 32 | Translated physical address (valid with done) |

## Verification
The assertions take for granted that the memory side answers only within a bounded time and that `mem_rd_data` is meaningful only in a cycle where `mem_rd_valid` meets an outstanding read; they place no condition on `pg_en` or `dir_base` while a walk runs. The stimulus answers each read after zero to three cycles. It also pulses `mem_rd_valid` with junk data in idle and done cycles to exercise R12, and it scrambles `pg_en` and `dir_base` in the middle of some walks. A behavioural reference model, driven only by the bench's own inputs, predicts every output on every cycle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_PDE = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_e;

endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        pg_en,
    input  logic        mem_rd_valid,
    input  logic        entry_present,
    output walk_state_e state_o,
    output logic        accept_o,
    output logic        bypass_o,
    output logic        pde_hit_o,
    output logic        pde_miss_o,
    output logic        pte_hit_o,
    output logic        pte_miss_o,
    output logic        req_ready_o,
    output logic        mem_rd_req_o,
    output logic        done_o
);

    walk_state_e state_q;
    walk_state_e state_d;

    // Transition events
    assign accept_o   = (state_q == ST_IDLE) && req_valid;
    assign bypass_o   = accept_o && !pg_en;
    assign pde_hit_o  = (state_q == ST_READ_PDE) && mem_rd_valid &&  entry_present;
    assign pde_miss_o = (state_q == ST_READ_PDE) && mem_rd_valid && !entry_present;
    assign pte_hit_o  = (state_q == ST_READ_PTE) && mem_rd_valid &&  entry_present;
    assign pte_miss_o = (state_q == ST_READ_PTE) && mem_rd_valid && !entry_present;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d = pg_en ? ST_READ_PDE : ST_DONE;
                end
            end
            ST_READ_PDE: begin
                if (pde_hit_o) begin
                    state_d = ST_READ_PTE;
                end else if (pde_miss_o) begin
                    state_d = ST_DONE;
                end
            end
            ST_READ_PTE: begin
                if (mem_rd_valid) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        req_ready_o  = 1'b0;
        mem_rd_req_o = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready_o  = 1'b1;
            ST_READ_PDE: mem_rd_req_o = 1'b1;
            ST_READ_PTE: mem_rd_req_o = 1'b1;
            ST_DONE:     done_o       = 1'b1;
            default:     req_ready_o  = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pgwalk_capture.sv
module pgwalk_capture #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [AW-1:0]       req_lin,
    input  logic [AW-1:0]       dir_base,
    output logic [AW-1:0]       lin_q,
    output logic [AW-OFF_W-1:0] base_frame_q
);

    logic unused_base_low;
    assign unused_base_low = ^dir_base[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q        <= '0;
            base_frame_q <= '0;
        end else if (accept) begin
            lin_q        <= req_lin;
            base_frame_q <= dir_base[AW-1:OFF_W];
        end
    end

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
    import pgwalk_pkg::*;
#(
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2,
    parameter int OFF_W    = IDX_W + ENT_LOG2,
    parameter int AW       = 2 * IDX_W + OFF_W
) (
    input  walk_state_e         state,
    input  logic [AW-1:0]       lin_q,
    input  logic [AW-OFF_W-1:0] base_frame,
    input  logic [AW-OFF_W-1:0] pde_frame,
    output logic [AW-1:0]       mem_rd_addr
);

    localparam int DIR_LSB = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = lin_q[DIR_LSB +: IDX_W];
    assign tbl_idx = lin_q[OFF_W +: IDX_W];

    always_comb begin
        mem_rd_addr = '0;
        unique case (state)
            ST_READ_PDE: mem_rd_addr = {base_frame, dir_idx, {ENT_LOG2{1'b0}}};
            ST_READ_PTE: mem_rd_addr = {pde_frame, tbl_idx, {ENT_LOG2{1'b0}}};
            default:     mem_rd_addr = '0;
        endcase
    end

endmodule

// File: rtl/pgwalk_result.sv
module pgwalk_result #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bypass,
    input  logic                pde_hit,
    input  logic                pde_miss,
    input  logic                pte_hit,
    input  logic                pte_miss,
    input  logic [AW-1:0]       req_lin,
    input  logic [AW-1:0]       lin_q,
    input  logic [AW-1:0]       mem_rd_data,
    output logic [AW-OFF_W-1:0] pde_frame_o,
    output logic [AW-1:0]       res_phys_o,
    output logic                res_fault_o
);

    logic unused_entry_bits;
    assign unused_entry_bits = ^mem_rd_data[OFF_W-1:0];

    // Directory entry frame, kept for the second read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pde_frame_o <= '0;
        end else if (pde_hit) begin
            pde_frame_o <= mem_rd_data[AW-1:OFF_W];
        end
    end

    // Final result of the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_phys_o  <= '0;
            res_fault_o <= 1'b0;
        end else if (bypass) begin
            res_phys_o  <= req_lin;
            res_fault_o <= 1'b0;
        end else if (pte_hit) begin
            res_phys_o  <= {mem_rd_data[AW-1:OFF_W], lin_q[OFF_W-1:0]};
            res_fault_o <= 1'b0;
        end else if (pde_miss || pte_miss) begin
            res_phys_o  <= '0;
            res_fault_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter  int IDX_W    = 10,
    parameter  int ENT_LOG2 = 2,
    localparam int OFF_W    = IDX_W + ENT_LOG2,
    localparam int AW       = 2 * IDX_W + OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_en,
    input  logic [AW-1:0] dir_base,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_lin,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] phys_addr
);

    localparam int FRM_W = AW - OFF_W;

    walk_state_e      state;
    logic             accept;
    logic             bypass;
    logic             pde_hit;
    logic             pde_miss;
    logic             pte_hit;
    logic             pte_miss;
    logic [AW-1:0]    lin_q;
    logic [FRM_W-1:0] base_frame;
    logic [FRM_W-1:0] pde_frame;
    logic [AW-1:0]    res_phys;
    logic             res_fault;

    pgwalk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .pg_en         (pg_en),
        .mem_rd_valid  (mem_rd_valid),
        .entry_present (mem_rd_data[0]),
        .state_o       (state),
        .accept_o      (accept),
        .bypass_o      (bypass),
        .pde_hit_o     (pde_hit),
        .pde_miss_o    (pde_miss),
        .pte_hit_o     (pte_hit),
        .pte_miss_o    (pte_miss),
        .req_ready_o   (req_ready),
        .mem_rd_req_o  (mem_rd_req),
        .done_o        (done)
    );

    pgwalk_capture #(.AW(AW), .OFF_W(OFF_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_lin      (req_lin),
        .dir_base     (dir_base),
        .lin_q        (lin_q),
        .base_frame_q (base_frame)
    );

    pgwalk_addr_gen #(
        .IDX_W    (IDX_W),
        .ENT_LOG2 (ENT_LOG2),
        .OFF_W    (OFF_W),
        .AW       (AW)
    ) u_addr_gen (
        .state       (state),
        .lin_q       (lin_q),
        .base_frame  (base_frame),
        .pde_frame   (pde_frame),
        .mem_rd_addr (mem_rd_addr)
    );

    pgwalk_result #(.AW(AW), .OFF_W(OFF_W)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass      (bypass),
        .pde_hit     (pde_hit),
        .pde_miss    (pde_miss),
        .pte_hit     (pte_hit),
        .pte_miss    (pte_miss),
        .req_lin     (req_lin),
        .lin_q       (lin_q),
        .mem_rd_data (mem_rd_data),
        .pde_frame_o (pde_frame),
        .res_phys_o  (res_phys),
        .res_fault_o (res_fault)
    );

    // Result is visible only in the done cycle
    assign phys_addr = done ? res_phys : '0;
    assign fault     = done & res_fault;

endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pg_en,
    input logic [AW-1:0] dir_base,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_lin,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_valid,
    input logic [AW-1:0] mem_rd_data,
    input logic          done,
    input logic          fault,
    input logic [AW-1:0] phys_addr
);

    logic unused_chk;
    assign unused_chk = ^{dir_base[11:0], mem_rd_data};

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_req && !done)); // R2

    AST_BYPASS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_en) |=>
            (done && !fault && !mem_rd_req && phys_addr == $past(req_lin))); // R3

    AST_PDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && pg_en) |=>
            (mem_rd_req && mem_rd_addr == {$past(dir_base[AW-1:12]), $past(req_lin[AW-1:22]), 2'b00})); // R4

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_req |-> (mem_rd_addr == '0)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R10

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && phys_addr == '0)); // R7

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (phys_addr == '0 && !fault)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready); // R12

endmodule

bind pgwalk_top pgwalk_checker #(.AW(AW)) chk_i (.*);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic        fault;
    logic [31:0] phys_addr;

    always #5 clk = ~clk;

    pgwalk_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_en        (pg_en),
        .dir_base     (dir_base),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_lin      (req_lin),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .done         (done),
        .fault        (fault),
        .phys_addr    (phys_addr)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    // Stimulus controls
    int fault_mode = 0;   // 0 all present, 1 dir absent, 2 table absent, 3 hashed
    bit spurious   = 1'b0;
    bit scramble   = 1'b0;

    // Reference model: 0 idle, 1 dir read, 2 table read, 3 done
    int          m_phase = 0;
    logic [31:0] m_lin = '0;
    logic [31:0] m_base = '0;
    bit          m_en = 1'b0;
    logic [31:0] m_pde = '0;
    logic [31:0] m_phys = '0;
    bit          m_fault = 1'b0;
    int          m_fsrc = 0;
    int          m_walks = 0;

    function automatic logic [31:0] mix(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5BD1_E995;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_lin  = req_lin;
                    m_base = dir_base;
                    m_en   = pg_en;
                    m_walks++;
                    if (!pg_en) begin
                        m_phys = req_lin; m_fault = 1'b0; m_phase = 3;
                    end else begin
                        m_phase = 1;
                    end
                end
                1: if (mem_rd_valid) begin
                    if (!mem_rd_data[0]) begin
                        m_phys = '0; m_fault = 1'b1; m_fsrc = 1; m_phase = 3;
                    end else begin
                        m_pde = mem_rd_data; m_phase = 2;
                    end
                end
                2: if (mem_rd_valid) begin
                    if (!mem_rd_data[0]) begin
                        m_phys = '0; m_fault = 1'b1; m_fsrc = 2;
                    end else begin
                        m_phys = {mem_rd_data[31:12], m_lin[11:0]}; m_fault = 1'b0;
                    end
                    m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Memory responder, driven from the model's phase
    int r_prev = 0;
    int r_wait = 0;
    int r_lat  = 0;
    always @(negedge clk) begin
        if (m_phase == 1 || m_phase == 2) begin
            logic [31:0] a;
            logic [31:0] h;
            bit present;
            if (m_phase != r_prev) begin
                r_wait = 0;
                r_lat  = $urandom_range(0, 3);
            end
            a = (m_phase == 1) ? {m_base[31:12], m_lin[31:22], 2'b00}
                               : {m_pde[31:12], m_lin[21:12], 2'b00};
            h = mix(a);
            present = 1'b1;
            if (fault_mode == 1 && m_phase == 1) present = 1'b0;
            if (fault_mode == 2 && m_phase == 2) present = 1'b0;
            if (fault_mode == 3 && h[7] && h[3]) present = 1'b0;
            if (r_wait >= r_lat) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = {h[31:1], present};
            end else begin
                mem_rd_valid = 1'b0;
                mem_rd_data  = $urandom;
            end
            r_wait++;
        end else begin
            mem_rd_valid = spurious && ($urandom_range(0, 1) == 1);
            mem_rd_data  = $urandom;
        end
        r_prev = m_phase;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            string tp;
            string ta;
            chk("R2", {31'd0, req_ready}, {31'd0, m_phase == 0}, "req_ready");
            chk("R9", {31'd0, mem_rd_req}, {31'd0, m_phase == 1 || m_phase == 2}, "mem_rd_req");
            if (m_phase == 1) ta = scramble ? "R11" : "R4";
            else if (m_phase == 2) ta = "R5";
            else ta = "R9";
            chk(ta, mem_rd_addr,
                (m_phase == 1) ? {m_base[31:12], m_lin[31:22], 2'b00} :
                (m_phase == 2) ? {m_pde[31:12], m_lin[21:12], 2'b00} : 32'h0, "mem_rd_addr");
            chk(spurious ? "R12" : "R10", {31'd0, done}, {31'd0, m_phase == 3}, "done");
            if (m_phase == 3) begin
                if (!m_en) tp = "R3";
                else if (!m_fault) tp = scramble ? "R11" : "R6";
                else tp = (m_fsrc == 1) ? "R7" : "R8";
                chk(tp, phys_addr, m_phys, "phys_addr");
                chk(tp, {31'd0, fault}, {31'd0, m_fault}, "fault");
            end else begin
                chk("R10", phys_addr, 32'h0, "phys_addr idle");
                chk("R10", {31'd0, fault}, 32'h0, "fault idle");
            end
        end
    end

    task automatic walk(input logic [31:0] lin, input logic [31:0] base, input bit en,
                        input bit poke);
        while (m_phase != 0) @(negedge clk);
        req_valid = 1'b1; req_lin = lin; dir_base = base; pg_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        while (m_phase != 0) begin
            if (poke) begin   // R2: requests while busy are ignored
                req_valid = 1'b1; req_lin = $urandom;
            end
            if (scramble) begin
                pg_en = $urandom_range(0, 1); dir_base = $urandom;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", {31'd0, req_ready}, 32'd1, "req_ready in reset");
        chk("R1", {31'd0, mem_rd_req}, 32'd0, "mem_rd_req in reset");
        chk("R1", {31'd0, done}, 32'd0, "done in reset");
        chk("R1", phys_addr, 32'd0, "phys_addr in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'd0, req_ready}, 32'd1, "req_ready after reset");

        // R3: bypass
        walk(32'hDEAD_BEEF, 32'h0001_2000, 1'b0, 1'b0);
        walk(32'h0000_0000, 32'h0001_2000, 1'b0, 1'b0);
        walk(32'hFFFF_FFFF, 32'h0001_2000, 1'b0, 1'b1);

        // R4/R5/R6: present walks, base low bits set
        fault_mode = 0;
        walk(32'h0040_1234, 32'h0010_0FFF, 1'b1, 1'b0);
        walk(32'hFFC0_0000, 32'h7FFF_F000, 1'b1, 1'b0);
        walk(32'h003F_FFFF, 32'h0000_0ABC, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) walk($urandom, $urandom, 1'b1, 1'b0);

        // R7 then R8: non-present entries
        fault_mode = 1;
        for (int i = 0; i < 4; i++) walk($urandom, $urandom, 1'b1, 1'b0);
        fault_mode = 2;
        for (int i = 0; i < 4; i++) walk($urandom, $urandom, 1'b1, 1'b0);

        // R2: pokes while busy
        fault_mode = 0;
        for (int i = 0; i < 6; i++) walk($urandom, $urandom, 1'b1, 1'b1);

        // R11: inputs scrambled mid-walk
        scramble = 1'b1;
        for (int i = 0; i < 10; i++) walk($urandom, $urandom, 1'b1, 1'b0);
        scramble = 1'b0;

        // R12: stray valid pulses outside reads
        spurious = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 10; i++) walk($urandom, $urandom, $urandom_range(0, 1), 1'b0);
        spurious = 1'b0;

        // Mixed traffic
        fault_mode = 3;
        for (int i = 0; i < 300; i++)
            walk($urandom, $urandom, ($urandom_range(0, 4) != 0), $urandom_range(0, 1));

        while (m_phase != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule